// File: doc/BRIEF.md
# Multi-Channel Mailbox Send Unit

This block is the sending half of an inter-processor mailbox. It serves eight destination channels. A host on a plain 32-bit register bus first loads a 64-bit message as a low word and a high word, then picks a destination channel number. A write to the trigger register posts the message. Each channel then holds its message until the far side acknowledges it.

Every channel runs a two-state machine. `CH_IDLE` moves to `CH_PEND` on the transition POST, which is a trigger aimed at that channel. `CH_PEND` returns to `CH_IDLE` on the transition ACK, which is the remote acknowledge for that channel and also sets the delivered flag. A trigger that reaches a channel in `CH_PEND` takes the REFUSE self-loop: the stored message is kept and the overflow flag sets.

A second two-state machine drives the interrupt. `IRQ_QUIET` moves to `IRQ_RAISED` on RAISE, an unmasked delivery or overflow event. `IRQ_RAISED` returns to `IRQ_QUIET` on CLEAR, a host write of bit 0 to the interrupt status register. Delivered and overflow flags are sticky. The host clears them through a separate clear register, using one mask bit per flag.

Top module: `mbx_send_unit`

## Requirements
- R1: After reset the status register (0x14) reads 0, the mask register (0x1C) reads 3'b111, the interrupt status (0x18) reads 0, `irq` is low and `chan_req` is 0.
- R2: A write of 1 in bit 0 to the trigger register (0x0C) sends the message to the idle channel whose number is held in bits 2:0 of 0x00. The message's low word comes from 0x04 (bits 31:0) and its high word from 0x08 (bits 63:32). From the next cycle that channel's busy bit (status bit `id`) and `chan_req[id]` are set, and `rmt_msg` shows the message while `rmt_sel` equals `id`.
- R3: A write to 0x0C with bit 0 clear changes no channel state.
- R4: An acknowledge on `chan_ack[i]` while channel i is busy clears busy bit i and sets delivered bit 16+i in the next cycle. An acknowledge on an idle channel changes nothing.
- R5: A trigger aimed at a busy channel keeps that channel's stored message and its busy state, and sets overflow bit 8+i.
- R6: A write to the clear register (0x10) clears delivered bit i where `wdata[16+i]` is 1 and overflow bit i where `wdata[8+i]` is 1. All other flags stay as they are.
- R7: Mask register bits are 0 block, 1 overflow, 2 deliver. A set bit suppresses that source, and an event from a suppressed source never raises `irq`.
- R8: An unmasked delivery or overflow event raises `irq` and bit 0 of 0x18 in the next cycle. Both stay high until bit 0 of 0x18 is written with 1. When an event and a clear fall in the same cycle, the event wins.
- R9: The ID (bits 2:0), low word, high word and mask registers read back the values last written to them.
- R10: When a trigger and an acknowledge reach the same busy channel in one cycle, the acknowledge completes: busy clears and delivered sets. The trigger counts as an overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| chan_ack | input | 8 | Per-channel acknowledge from the remote side |
| chan_req | output | 8 | Per-channel pending message indication |
| rmt_sel | input | 3 | Channel whose stored message is shown on `rmt_msg` |
| rmt_msg | output | 64 | Stored message of the selected channel |
| irq | output | 1 | Interrupt request, active high |

## Verification
The assertions rely on a few things about the inputs. `chan_ack` may arrive on any channel in any cycle, including on idle channels and in the same cycle as a trigger. Bus writes are single-cycle strobes to word-aligned addresses. The stimulus keeps to these rules: every write is a one-cycle strobe at an aligned offset, and acknowledges are one-cycle pulses. Some acknowledges are deliberately placed on idle channels. Others are placed together with a trigger or an interrupt clear, to exercise the same-cycle priority rules.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int NUM_CH = 8;
    localparam int DATA_W = 32;
    localparam int MSG_W  = 2 * DATA_W;
    localparam int ADDR_W = 6;
    localparam int ID_W   = $clog2(NUM_CH);
    localparam int MASK_W = 3;

    localparam logic [ADDR_W-1:0] OFS_ID   = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_LO   = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_HI   = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_TRIG = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_CLR  = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_STAT = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_IRQ  = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_MASK = 6'h1C;

    localparam int ST_BUSY_LSB = 0;
    localparam int ST_OVF_LSB  = 8;
    localparam int ST_DLV_LSB  = 16;

    localparam int SRC_BLOCK = 0;
    localparam int SRC_OVF   = 1;
    localparam int SRC_DLV   = 2;

    typedef enum logic {CH_IDLE, CH_PEND} ch_state_e;
    typedef enum logic {IRQ_QUIET, IRQ_RAISED} irq_state_e;
endpackage

// File: rtl/mbx_regs.sv
module mbx_regs
    import mbx_pkg::*;
#(
    parameter int N_CH = NUM_CH,
    parameter int DW   = DATA_W,
    parameter int AW   = ADDR_W,
    localparam int IW  = $clog2(N_CH),
    localparam int MW  = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic [N_CH-1:0] st_busy,
    input  logic [N_CH-1:0] st_ovf,
    input  logic [N_CH-1:0] st_dlv,
    input  logic          irq_q,
    output logic [IW-1:0] id_q,
    output logic [MW-1:0] msg_q,
    output logic [MASK_W-1:0] mask_q,
    output logic          post_stb,
    output logic [N_CH-1:0] clr_ovf,
    output logic [N_CH-1:0] clr_dlv,
    output logic          irq_clr,
    output logic [DW-1:0] bus_rdata
);
    logic [DW-1:0] lo_q, hi_q;
    logic [DW-1:0] stat_word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_q   <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
            mask_q <= '1;
        end else if (bus_wr) begin
            if (bus_addr == OFS_ID)   id_q   <= bus_wdata[IW-1:0];
            if (bus_addr == OFS_LO)   lo_q   <= bus_wdata;
            if (bus_addr == OFS_HI)   hi_q   <= bus_wdata;
            if (bus_addr == OFS_MASK) mask_q <= bus_wdata[MASK_W-1:0];
        end
    end

    assign msg_q    = {hi_q, lo_q};
    assign post_stb = bus_wr && (bus_addr == OFS_TRIG) && bus_wdata[0];
    assign irq_clr  = bus_wr && (bus_addr == OFS_IRQ) && bus_wdata[0];
    assign clr_ovf  = (bus_wr && bus_addr == OFS_CLR) ? bus_wdata[ST_OVF_LSB +: N_CH] : '0;
    assign clr_dlv  = (bus_wr && bus_addr == OFS_CLR) ? bus_wdata[ST_DLV_LSB +: N_CH] : '0;

    always_comb begin
        stat_word = '0;
        stat_word[ST_BUSY_LSB +: N_CH] = st_busy;
        stat_word[ST_OVF_LSB  +: N_CH] = st_ovf;
        stat_word[ST_DLV_LSB  +: N_CH] = st_dlv;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_ID:   bus_rdata[IW-1:0] = id_q;
            OFS_LO:   bus_rdata = lo_q;
            OFS_HI:   bus_rdata = hi_q;
            OFS_STAT: bus_rdata = stat_word;
            OFS_IRQ:  bus_rdata[0] = irq_q;
            OFS_MASK: bus_rdata[MASK_W-1:0] = mask_q;
            default:  bus_rdata = '0;
        endcase
    end

    // A write to the mask register must be visible on the next cycle
    assert_mask_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == OFS_MASK |=> mask_q == $past(bus_wdata[MASK_W-1:0]));
endmodule

// File: rtl/mbx_chan.sv
module mbx_chan
    import mbx_pkg::*;
#(
    parameter int MW = MSG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          post,
    input  logic          ack,
    input  logic          clr_ovf,
    input  logic          clr_dlv,
    input  logic [MW-1:0] msg_in,
    output logic          busy,
    output logic          ovf_q,
    output logic          dlv_q,
    output logic          ovf_evt,
    output logic          dlv_evt,
    output logic [MW-1:0] msg_q
);
    ch_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (post) state_d = CH_PEND;
            CH_PEND: if (ack)  state_d = CH_IDLE;
        endcase
    end

    assign busy    = (state_q == CH_PEND);
    assign dlv_evt = busy && ack;
    assign ovf_evt = busy && post;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            dlv_q <= 1'b0;
            msg_q <= '0;
        end else begin
            if (ovf_evt)      ovf_q <= 1'b1;
            else if (clr_ovf) ovf_q <= 1'b0;
            if (dlv_evt)      dlv_q <= 1'b1;
            else if (clr_dlv) dlv_q <= 1'b0;
            if (post && !busy) msg_q <= msg_in;
        end
    end

    assert_post_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        post && state_q == CH_IDLE |=> busy);
    assert_ack_deliver_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ack && state_q == CH_PEND |=> dlv_q && state_q == CH_IDLE);
    assert_ack_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ack && !post && state_q == CH_IDLE |=> state_q == CH_IDLE);
    assert_no_overwrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == CH_PEND && !ack |=> $stable(msg_q) && busy);
    assert_refuse_ovf_R5: assert property (@(posedge clk) disable iff (!rst_n)
        post && state_q == CH_PEND |=> ovf_q);
    assert_race_R10: assert property (@(posedge clk) disable iff (!rst_n)
        post && ack && state_q == CH_PEND |=> ovf_q && dlv_q && !busy);
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq
    import mbx_pkg::*;
#(
    parameter int N_CH = NUM_CH
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] ovf_evt,
    input  logic [N_CH-1:0] dlv_evt,
    input  logic            mask_ovf,
    input  logic            mask_dlv,
    input  logic            clr,
    output logic            irq
);
    irq_state_e state_q, state_d;
    logic raise;

    assign raise = (|ovf_evt && !mask_ovf) || (|dlv_evt && !mask_dlv);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (raise)         state_d = IRQ_RAISED;
            IRQ_RAISED: if (clr && !raise) state_d = IRQ_QUIET;
        endcase
    end

    assign irq = (state_q == IRQ_RAISED);

    assert_irq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !clr |=> irq);
    assert_irq_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        |dlv_evt && !mask_dlv |=> irq);
    assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !irq && mask_ovf && mask_dlv |=> !irq);
endmodule

// File: rtl/mbx_send_unit.sv
module mbx_send_unit
    import mbx_pkg::*;
#(
    parameter int N_CH = NUM_CH,
    parameter int DW   = DATA_W,
    parameter int AW   = ADDR_W,
    localparam int IW  = $clog2(N_CH),
    localparam int MW  = 2 * DW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [N_CH-1:0] chan_ack,
    output logic [N_CH-1:0] chan_req,
    input  logic [IW-1:0]   rmt_sel,
    output logic [MW-1:0]   rmt_msg,
    output logic            irq
);
    logic [IW-1:0]     id_q;
    logic [MW-1:0]     msg_q;
    logic [MASK_W-1:0] mask_q;
    logic              post_stb, irq_clr;
    logic [N_CH-1:0]   clr_ovf, clr_dlv;
    logic [N_CH-1:0]   busy, ovf, dlv, ovf_evt, dlv_evt;
    logic [MW-1:0]     store [N_CH];

    mbx_regs #(.N_CH(N_CH), .DW(DW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .st_busy(busy), .st_ovf(ovf), .st_dlv(dlv),
        .irq_q(irq), .id_q(id_q), .msg_q(msg_q), .mask_q(mask_q),
        .post_stb(post_stb), .clr_ovf(clr_ovf), .clr_dlv(clr_dlv),
        .irq_clr(irq_clr), .bus_rdata(bus_rdata)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        mbx_chan #(.MW(MW)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .post(post_stb && id_q == IW'(g)),
            .ack(chan_ack[g]),
            .clr_ovf(clr_ovf[g]), .clr_dlv(clr_dlv[g]),
            .msg_in(msg_q),
            .busy(busy[g]), .ovf_q(ovf[g]), .dlv_q(dlv[g]),
            .ovf_evt(ovf_evt[g]), .dlv_evt(dlv_evt[g]),
            .msg_q(store[g])
        );
    end

    mbx_irq #(.N_CH(N_CH)) u_irq (
        .clk(clk), .rst_n(rst_n), .ovf_evt(ovf_evt), .dlv_evt(dlv_evt),
        .mask_ovf(mask_q[SRC_OVF]), .mask_dlv(mask_q[SRC_DLV]),
        .clr(irq_clr), .irq(irq)
    );

    assign chan_req = busy;
    assign rmt_msg  = store[rmt_sel];

    // Requests only change through a trigger or an acknowledge
    assert_req_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !post_stb && chan_ack == '0 |=> $stable(chan_req));
endmodule

// File: tb/tb_mbx_send_unit.sv
module tb_mbx_send_unit;
    import mbx_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  chan_ack = '0;
    logic [7:0]  chan_req;
    logic [2:0]  rmt_sel = '0;
    logic [63:0] rmt_msg;
    logic        irq;
    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    mbx_send_unit dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .chan_ack(chan_ack),
        .chan_req(chan_req), .rmt_sel(rmt_sel), .rmt_msg(rmt_msg), .irq(irq)
    );

    typedef struct packed {
        logic [1:0]  op;    // 0 write, 1 acknowledge pulse, 2 idle cycle
        logic [5:0]  addr;
        logic [31:0] data;
        logic [5:0]  chk;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 6'h1C, 32'h0,        6'h1C, 32'h0,        8'd9},  // R9 unmask all
        '{2'd0, 6'h00, 32'h3,        6'h00, 32'h3,        8'd9},  // R9 id
        '{2'd0, 6'h04, 32'h11112222, 6'h04, 32'h11112222, 8'd9},  // R9 low
        '{2'd0, 6'h08, 32'h33334444, 6'h08, 32'h33334444, 8'd9},  // R9 high
        '{2'd0, 6'h0C, 32'h0,        6'h14, 32'h0,        8'd3},  // R3 bit0 clear
        '{2'd0, 6'h0C, 32'h1,        6'h14, 32'h08,       8'd2},  // R2 post ch3
        '{2'd0, 6'h0C, 32'h1,        6'h14, 32'h0808,     8'd5},  // R5 refused
        '{2'd2, 6'h00, 32'h0,        6'h18, 32'h1,        8'd8},  // R8 irq pending
        '{2'd0, 6'h18, 32'h1,        6'h18, 32'h0,        8'd8},  // R8 clear
        '{2'd1, 6'h00, 32'h08,       6'h14, 32'h00080800, 8'd4},  // R4 deliver
        '{2'd0, 6'h10, 32'h00000800, 6'h14, 32'h00080000, 8'd6},  // R6 ovf clear
        '{2'd0, 6'h10, 32'h00080000, 6'h14, 32'h0,        8'd6},  // R6 dlv clear
        '{2'd1, 6'h00, 32'h01,       6'h14, 32'h0,        8'd4}   // R4 idle ack
    };

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic ack_pulse(input logic [7:0] m);
        @(negedge clk);
        chan_ack = m;
        @(negedge clk);
        chan_ack = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(6'h14, v); check("R1 status", 64'(v), 64'h0);
        rd(6'h1C, v); check("R1 mask", 64'(v), 64'h7);
        rd(6'h18, v); check("R1 irq status", 64'(v), 64'h0);
        check("R1 irq pin", 64'(irq), 64'h0);
        check("R1 chan_req", 64'(chan_req), 64'h0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].op == 2'd0)      wr(VECS[i].addr, VECS[i].data);
            else if (VECS[i].op == 2'd1) ack_pulse(VECS[i].data[7:0]);
            else                         @(negedge clk);
            rd(VECS[i].chk, v);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), 64'(v), 64'(VECS[i].exp));
        end

        // R2 message delivery to channel 5
        wr(6'h00, 32'h5);
        wr(6'h04, 32'hAAAA0001);
        wr(6'h08, 32'hBBBB0002);
        wr(6'h0C, 32'h1);
        rmt_sel = 3'd5;
        #1;
        check("R2 message", rmt_msg, 64'hBBBB0002_AAAA0001);
        check("R2 chan_req", 64'(chan_req), 64'h20);

        // R5 refused trigger keeps the stored message
        wr(6'h04, 32'hDEAD0000);
        wr(6'h0C, 32'h1);
        #1;
        check("R5 message kept", rmt_msg, 64'hBBBB0002_AAAA0001);
        rd(6'h14, v); check("R5 status", 64'(v), 64'h2020);

        // R7 masked sources leave irq low
        wr(6'h1C, 32'h7);
        wr(6'h18, 32'h1);
        check("R7 irq cleared", 64'(irq), 64'h0);
        ack_pulse(8'h20);
        check("R7 irq masked", 64'(irq), 64'h0);
        rd(6'h14, v); check("R7 delivered", 64'(v), 64'h00202000);

        // R6 clear all sticky flags
        wr(6'h10, 32'h00FFFF00);
        rd(6'h14, v); check("R6 clear all", 64'(v), 64'h0);

        // R10 trigger and acknowledge on the same busy channel
        wr(6'h0C, 32'h1);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 6'h0C; bus_wdata = 32'h1; chan_ack = 8'h20;
        @(negedge clk);
        bus_wr = 1'b0; chan_ack = '0;
        rd(6'h14, v); check("R10 race status", 64'(v), 64'h00202000);
        check("R10 chan_req", 64'(chan_req), 64'h0);

        // R8 event in the same cycle as a clear keeps irq high
        wr(6'h1C, 32'h0);
        wr(6'h0C, 32'h1);
        check("R8 irq before", 64'(irq), 64'h0);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 6'h18; bus_wdata = 32'h1; chan_ack = 8'h20;
        @(negedge clk);
        bus_wr = 1'b0; chan_ack = '0;
        #1;
        check("R8 set wins", 64'(irq), 64'h1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule